// File: doc/BRIEF.md
# SRAM Command Turnaround Scheduler

This block sits in front of the command port of a synchronous SRAM whose data pins may be one shared bidirectional bus. A request source hands it reads and writes one at a time. In every clock cycle the block issues exactly one command: read, write or no-operation (NOP). When a write would follow a read too closely on a shared bus, it holds the write back and issues NOP cycles instead. This leaves the memory time to release the bus before the controller drives write data onto it. Reads are never held back: the memory's own read latency already covers the change from writing to reading.

The number of NOP cycles required between a read and a following write is the parameter `TURN_NOPS`, 1 or 2, with 2 as the default. The two-NOP setting leaves one bus cycle that carries neither read data nor write data, which high clock rates need. The `split_mode` input tells the block that data in and data out are on separate pins; in that case no NOP is ever inserted. The block also drives the controller-side write data and its output enable, one cycle after each write command.

Requests use a valid/ready handshake. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is a combinational function of `req_is_write`, `split_mode` and internal state: it is low only for a write presented while the read-to-write gap is still open. The source must hold `req_is_write` and `req_wdata` stable while `req_valid` is high and the request has not been taken. Requests are issued strictly in the order they are taken.

Top module: `sram_turn_sched`

## Requirements
- R1: In each cycle the command is a read (`cmd_rd`=1, `cmd_wr`=0), a write (`cmd_wr`=1, `cmd_rd`=0) or a NOP (both 0); the two strobes are never high together.
- R2: A request taken on a clock edge appears as its command in the cycle right after that edge, in the order taken; a cycle that follows an edge with no handshake carries a NOP.
- R3: With `split_mode`=0, no write command is issued in the `TURN_NOPS` cycles after a read command. A write presented right after its read is issued exactly `TURN_NOPS`+1 cycles after the read command, for both 1 and 2.
- R4: While the read-to-write gap is open and `split_mode`=0, a valid write sees `req_ready` low. Read commands issued in split mode also open the gap for a later shared-mode write.
- R5: Cycles with no request count toward the gap, so a write presented after enough idle cycles is taken at once.
- R6: Reads are never stalled: a read is taken immediately after a write and after another read.
- R7: With `split_mode`=1, no request is ever stalled, whatever the order of reads and writes.
- R8: `dq_oe` is high exactly in the cycle after a write command, with `dq_out` carrying that write's data; it is low in all other cycles.
- R9: For writes taken with `split_mode`=0, `dq_oe` is never high in the two cycles after a read command, which are the cycles the memory drives read data.
- R10: During and after reset, `cmd_rd`, `cmd_wr` and `dq_oe` are low, and the gap counts as already closed, so the first write is taken without a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| split_mode | input | 1 | 1: separate data in/out pins, no turnaround; 0: shared bus |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_is_write | input | 1 | 1: write request, 0: read request |
| req_wdata | input | DATA_W | Write data of the request |
| cmd_rd | output | 1 | Read command strobe |
| cmd_wr | output | 1 | Write command strobe |
| dq_out | output | DATA_W | Write data toward the bus, valid with dq_oe |
| dq_oe | output | 1 | Controller drive enable for the data bus |

## Verification
The two functions that can land in the same cycle are the controller driving write data and the memory returning data for an earlier read. The bench provokes this by presenting a write in the cycle right after a read is taken, in shared and split mode and with both settings of `TURN_NOPS`. In shared mode it judges the number of stalled cycles against the expected count and checks that the enable cycle falls outside the two read-data cycles. In split mode the overlap is allowed, and the check is that the write goes through with no stall.

// File: rtl/sram_ts_pkg.sv
package sram_ts_pkg;
  localparam int unsigned MAX_NOPS = 2;

  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_RD  = 2'd1,
    OP_WR  = 2'd2
  } op_e;

  function automatic int unsigned clamp_nops(input int unsigned n);
    if (n < 1) return 1;
    if (n > MAX_NOPS) return MAX_NOPS;
    return n;
  endfunction
endpackage

// File: rtl/sram_ts_gap.sv
module sram_ts_gap #(
  parameter int unsigned NOPS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_rd,
  output logic gap_ok
);
  localparam int unsigned GW = $clog2(NOPS + 1);
  localparam logic [GW-1:0] FULL = GW'(NOPS);

  // cycles elapsed since the last read command, saturating at NOPS
  logic [GW-1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age_q <= FULL;
    else if (acc_rd)     age_q <= '0;
    else if (age_q != FULL) age_q <= age_q + 1'b1;
  end

  assign gap_ok = (age_q == FULL);

  // R4: a read just taken always opens the gap
  a_r4_gap_opens: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> !gap_ok);
endmodule

// File: rtl/sram_ts_issue.sv
module sram_ts_issue
  import sram_ts_pkg::*;
#(
  parameter int unsigned NOPS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_is_write,
  input  logic split_mode,
  input  logic gap_ok,
  output logic req_ready,
  output logic acc_rd,
  output logic acc_wr,
  output logic cmd_rd,
  output logic cmd_wr
);
  op_e  op_q;
  logic shared_q;
  logic acc;

  // only a shared-bus write with an open gap is held back
  assign req_ready = !(req_is_write && !split_mode && !gap_ok);
  assign acc       = req_valid && req_ready;
  assign acc_rd    = acc && !req_is_write;
  assign acc_wr    = acc && req_is_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q     <= OP_NOP;
      shared_q <= 1'b0;
    end else begin
      op_q     <= acc_wr ? OP_WR : (acc_rd ? OP_RD : OP_NOP);
      shared_q <= !split_mode;
    end
  end

  assign cmd_rd = (op_q == OP_RD);
  assign cmd_wr = (op_q == OP_WR);

  // R1: never both strobes
  a_r1_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_rd && cmd_wr));

  // R2: handshake gives a command next cycle, none gives a NOP
  a_r2_cmd_follows: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (cmd_rd || cmd_wr));
  a_r2_nop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> (!cmd_rd && !cmd_wr));

  // R3: shared-bus write keeps clear of recent read commands
  a_r3_gap_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && shared_q) |-> !$past(cmd_rd));

  generate
    if (NOPS >= 2) begin : g_two
      a_r3_gap_two: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && shared_q) |-> !$past(cmd_rd, 2));
    end
  endgenerate
endmodule

// File: rtl/sram_ts_wpipe.sv
module sram_ts_wpipe #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_wr,
  input  logic              shared,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              oe_shared
);
  logic              s1_v;
  logic              s1_sh;
  logic [DATA_W-1:0] s1_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v      <= 1'b0;
      s1_sh     <= 1'b0;
      s1_d      <= '0;
      dq_oe     <= 1'b0;
      oe_shared <= 1'b0;
      dq_out    <= '0;
    end else begin
      s1_v      <= acc_wr;
      s1_sh     <= shared;
      s1_d      <= acc_wr ? wdata : '0;
      dq_oe     <= s1_v;
      oe_shared <= s1_v && s1_sh;
      dq_out    <= s1_v ? s1_d : '0;
    end
  end
endmodule

// File: rtl/sram_turn_sched.sv
module sram_turn_sched
  import sram_ts_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned TURN_NOPS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              split_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_is_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              cmd_rd,
  output logic              cmd_wr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  localparam int unsigned NOPS = clamp_nops(TURN_NOPS);

  logic gap_ok;
  logic acc_rd;
  logic acc_wr;
  logic oe_shared;

  sram_ts_gap #(.NOPS(NOPS)) u_gap (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc_rd (acc_rd),
    .gap_ok (gap_ok)
  );

  sram_ts_issue #(.NOPS(NOPS)) u_issue (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_is_write (req_is_write),
    .split_mode   (split_mode),
    .gap_ok       (gap_ok),
    .req_ready    (req_ready),
    .acc_rd       (acc_rd),
    .acc_wr       (acc_wr),
    .cmd_rd       (cmd_rd),
    .cmd_wr       (cmd_wr)
  );

  sram_ts_wpipe #(.DATA_W(DATA_W)) u_wpipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_wr    (acc_wr),
    .shared    (!split_mode),
    .wdata     (req_wdata),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .oe_shared (oe_shared)
  );

  // read data window: the two cycles after a read command
  logic rd_d1, rd_d2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_d1 <= 1'b0;
      rd_d2 <= 1'b0;
    end else begin
      rd_d1 <= cmd_rd;
      rd_d2 <= rd_d1;
    end
  end

  // R8: enable exactly one cycle after each write command
  a_r8_oe_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> dq_oe);
  a_r8_oe_only_wr: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> !dq_oe);

  // R9: shared-bus drive never meets returning read data
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && oe_shared) |-> !(rd_d1 || rd_d2));
endmodule

// File: tb/sram_turn_sched_tb.sv
module sram_turn_sched_tb;
  localparam int TCLK = 10;
  localparam int DW   = 16;

  typedef struct packed {
    logic          split;
    logic          wr;
    logic [DW-1:0] data;
    logic [1:0]    idle;
    logic [1:0]    wait_c;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 16'hA001, 2'd0, 2'd0},  // R10 first write free
    '{1'b0, 1'b0, 16'h0000, 2'd0, 2'd0},  // R6 read after write
    '{1'b0, 1'b1, 16'hA002, 2'd0, 2'd2},  // R3 write right after read
    '{1'b0, 1'b0, 16'h0000, 2'd0, 2'd0},  // R6
    '{1'b0, 1'b0, 16'h0000, 2'd0, 2'd0},  // R6 back-to-back reads
    '{1'b0, 1'b1, 16'hA003, 2'd1, 2'd1},  // R5 one idle counts
    '{1'b0, 1'b0, 16'h0000, 2'd0, 2'd0},  // R6
    '{1'b0, 1'b1, 16'hA004, 2'd2, 2'd0},  // R5 late write free
    '{1'b1, 1'b0, 16'h0000, 2'd0, 2'd0},  // R7
    '{1'b1, 1'b1, 16'hA005, 2'd0, 2'd0},  // R7 split write after read
    '{1'b1, 1'b1, 16'hA006, 2'd0, 2'd0},  // R7
    '{1'b1, 1'b0, 16'h0000, 2'd0, 2'd0},  // R7
    '{1'b0, 1'b1, 16'hA007, 2'd0, 2'd2}   // R4 split read opens gap
  };

  function automatic string tag_of(input int i);
    case (i)
      0: return "R10";
      2: return "R3";
      5, 7: return "R5";
      8, 9, 10, 11: return "R7";
      12: return "R4";
      default: return "R6";
    endcase
  endfunction

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic split = 1'b0, valid = 1'b0, is_wr = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic ready, crd, cwr, oe;
  logic [DW-1:0] dout;

  logic v1 = 1'b0, w1 = 1'b0;
  logic [DW-1:0] d1 = '0;
  logic split1 = 1'b0;
  logic rdy1, crd1, cwr1, oe1;
  logic [DW-1:0] dout1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic mon_en = 1'b0;

  logic          e_rd [8];
  logic          e_wr [8];
  logic          e_oe [8];
  logic          e_sh [8];
  logic [DW-1:0] e_d  [8];
  logic brd1 = 1'b0, brd2 = 1'b0;

  always #(TCLK/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sram_turn_sched #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .split_mode(split), .req_valid(valid),
    .req_ready(ready), .req_is_write(is_wr), .req_wdata(wdata),
    .cmd_rd(crd), .cmd_wr(cwr), .dq_out(dout), .dq_oe(oe));

  sram_turn_sched #(.DATA_W(DW), .TURN_NOPS(1)) u_dut1 (
    .clk(clk), .rst_n(rst_n), .split_mode(split1), .req_valid(v1),
    .req_ready(rdy1), .req_is_write(w1), .req_wdata(d1),
    .cmd_rd(crd1), .cmd_wr(cwr1), .dq_out(dout1), .dq_oe(oe1));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic clear_exp();
    for (int i = 0; i < 8; i++) begin
      e_rd[i] = 1'b0; e_wr[i] = 1'b0; e_oe[i] = 1'b0; e_sh[i] = 1'b0; e_d[i] = '0;
    end
  endtask

  // per-cycle port monitor for u_dut
  always @(negedge clk) begin
    if (mon_en && rst_n) begin
      int s;
      s = cyc % 8;
      chk(!(crd && cwr), "R1 both strobes", {crd, cwr}, 0);
      chk(crd == e_rd[s], "R2 read strobe", crd, e_rd[s]);
      chk(cwr == e_wr[s], "R2 write strobe", cwr, e_wr[s]);
      chk(oe == e_oe[s], "R8 output enable", oe, e_oe[s]);
      if (e_oe[s]) chk(dout == e_d[s], "R8 write data", dout, e_d[s]);
      if (oe && e_sh[s]) chk(!(brd1 || brd2), "R9 drive in read window", {brd1, brd2}, 0);
      e_rd[s] = 1'b0; e_wr[s] = 1'b0; e_oe[s] = 1'b0; e_sh[s] = 1'b0;
    end
    brd2 = brd1;
    brd1 = crd;
  end

  // called at negedge+1 of a cycle; returns at negedge+1 after acceptance
  task automatic send(input vec_t v, output int waited);
    valid = 1'b0;
    repeat (v.idle) begin @(negedge clk); #1; end
    split = v.split; is_wr = v.wr; wdata = v.data; valid = 1'b1;
    #1;
    waited = 0;
    while (!ready) begin
      waited++;
      @(negedge clk); #2;
    end
    begin
      int s1, s2;
      s1 = (cyc + 1) % 8;
      s2 = (cyc + 2) % 8;
      e_rd[s1] = !v.wr;
      e_wr[s1] = v.wr;
      if (v.wr) begin
        e_oe[s2] = 1'b1;
        e_sh[s2] = !v.split;
        e_d[s2]  = v.data;
      end
    end
    @(negedge clk); #1;
    valid = 1'b0;
  endtask

  initial begin
    #(TCLK * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int w;
    clear_exp();
    // R10: reset state with a write waiting
    valid = 1'b1; is_wr = 1'b1; wdata = 16'h1234;
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    chk(!crd && !cwr && !oe, "R10 outputs in reset", {crd, cwr, oe}, 0);
    chk(ready == 1'b1, "R10 ready in reset", ready, 1);
    valid = 1'b0;
    rst_n = 1'b1;
    mon_en = 1'b1;
    @(negedge clk); #1;

    // table walk (TURN_NOPS = 2)
    for (int i = 0; i < NV; i++) begin
      send(VEC[i], w);
      chk(w == int'(VEC[i].wait_c), {tag_of(i), " stall cycles"}, w, VEC[i].wait_c);
    end
    repeat (3) begin @(negedge clk); #1; end

    // R10: reset right after a read clears the gap
    begin
      vec_t rv;
      rv = '{1'b0, 1'b0, 16'h0000, 2'd0, 2'd0};
      send(rv, w);
    end
    mon_en = 1'b0;
    rst_n = 1'b0;
    @(negedge clk); #1;
    chk(!crd && !cwr && !oe, "R10 outputs after mid reset", {crd, cwr, oe}, 0);
    clear_exp();
    rst_n = 1'b1;
    #1;
    mon_en = 1'b1;
    begin
      vec_t wv;
      wv = '{1'b0, 1'b1, 16'hB00B, 2'd0, 2'd0};
      send(wv, w);
      chk(w == 0, "R10 write after reset stall", w, 0);
    end
    repeat (3) begin @(negedge clk); #1; end

    // R3 with TURN_NOPS = 1 on u_dut1
    v1 = 1'b1; w1 = 1'b0; #1;
    chk(rdy1 == 1'b1, "R6 read ready nops1", rdy1, 1);
    @(negedge clk); #1;
    w1 = 1'b1; d1 = 16'hC0DE; #1;
    chk(crd1 == 1'b1, "R2 read issued nops1", crd1, 1);
    w = 0;
    while (!rdy1 && w < 5) begin w++; @(negedge clk); #2; end
    chk(w == 1, "R3 stall cycles nops1", w, 1);
    @(negedge clk); #1;
    v1 = 1'b0;
    chk(cwr1 == 1'b1, "R3 write issued two after read nops1", cwr1, 1);
    @(negedge clk); #1;
    chk(oe1 == 1'b1 && dout1 == 16'hC0DE, "R8 data nops1", dout1, 16'hC0DE);
    @(negedge clk); #1;
    chk(oe1 == 1'b0, "R8 enable drops nops1", oe1, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule